// File: doc/BRIEF.md
# Counter Bit-Rise Interval Trigger

This block keeps a free-running up-counter and watches four fixed bit positions of it. An event occurs when a watched bit goes from 0 to 1 as the counter steps. Watching a higher bit gives a longer event period. Each of the four sources has two enable bits. One lets the source latch a sticky status flag, which feeds a single shared interrupt line. The other lets the source produce a one-clock pulse that starts an A/D conversion.

Software writes all eight enable bits in one register write. It reads the four status flags and clears them by writing 1s. A count-enable strobe, normally driven by an outside prescaler, sets the rate of the counter. The counter value is available as an output.

Top module: `bit_interval_trigger`

## Requirements
- R1: While rst_ni is low and after reset: cnt_o is 0, stat_o is 0, irq_o is 0, ad_trig_o is 0, and all enable bits are 0.
- R2: On each rising clock edge with cnt_en_i high, cnt_o increases by 1, wrapping modulo 2^CNT_W. With cnt_en_i low it holds its value.
- R3: Source i (i = 0..3) watches counter bit 6+i. The source has an event only on an increment that changes that bit from 0 to 1. A 1-to-0 change, or a cycle with no increment, gives no event.
- R4: The interrupt enables sit in cfg_wdata_i[3:0], with bit i for source i. An event on a source whose interrupt enable is set sets stat_o[i] on the same edge that updates the counter.
- R5: The A/D enables sit in cfg_wdata_i[7:4], with bit 4+i for source i. An event on a source whose A/D enable is set drives ad_trig_o high for exactly the one clock that follows the counter update.
- R6: irq_o is high exactly when some stat_o[i] is set and its interrupt enable is set. A flag stays set when its enable is later cleared, but it is then masked from irq_o.
- R7: On an edge with stat_we_i high, every stat_o bit whose stat_wdata_i bit is 1 is cleared. Bits written as 0 are unchanged.
- R8: If an event sets a flag on the same edge that a clear targets it, the flag stays set.
- R9: With both enables of a source at 0, its events change neither stat_o nor ad_trig_o.
- R10: The enable register loads cfg_wdata_i only on an edge with cfg_we_i high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-enable strobe |
| cfg_we_i | input | 1 | Enable register write strobe |
| cfg_wdata_i | input | 8 | [3:0] interrupt enables, [7:4] A/D enables |
| stat_we_i | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata_i | input | 4 | Status clear mask |
| stat_o | output | 4 | Status flags, one per source |
| cnt_o | output | 32 | Counter value |
| irq_o | output | 1 | Combined interrupt request |
| ad_trig_o | output | 1 | One-clock A/D start pulse |

## Verification
The assertions check on every cycle that the counter steps by one or holds, and that a rise is flagged only on an increment. They also check that a cleared flag falls unless an event sets it again, that an event keeps its flag set against a clear, that the A/D pulse never lasts two clocks, and that the interrupt never rises without a flag. The bench scenarios are needed to show the correct bit-to-source mapping and the exact count at which each source fires. They also show how many pulses a long run gives, and that masking, enable writes and partial clears work as described.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned CNT_W     = 32;
  localparam int unsigned NUM_SRC   = 4;
  localparam int unsigned WATCH_LSB = 6;
  localparam int unsigned CFG_W     = 2 * NUM_SRC;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef struct packed {
    src_vec_t ad_en;
    src_vec_t irq_en;
  } ivt_cfg_t;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_en_i) cnt_q <= cnt_nxt_o;
  end

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_q));
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/ivt_rise_detect.sv
module ivt_rise_detect #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_SRC   = 4,
  parameter int unsigned WATCH_LSB = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   cnt_nxt_i,
  output logic [NUM_SRC-1:0] rise_o
);
  // compare each watched bit against its value before the step
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int unsigned BIT = WATCH_LSB + g;
    assign rise_o[g] = cnt_en_i & ~cnt_i[BIT] & cnt_nxt_i[BIT];
  end

  assert_rise_needs_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |-> cnt_en_i);
  assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rise_o));
endmodule

// File: rtl/ivt_status.sv
module ivt_status
  import ivt_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [2*NUM_SRC-1:0] cfg_wdata_i,
  input  logic               stat_we_i,
  input  logic [NUM_SRC-1:0] stat_wdata_i,
  input  logic [NUM_SRC-1:0] rise_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] ad_fire_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] irq_en_q, ad_en_q, stat_q, set_vec, clr_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= '0;
      ad_en_q  <= '0;
    end else if (cfg_we_i) begin
      irq_en_q <= cfg_wdata_i[NUM_SRC-1:0];
      ad_en_q  <= cfg_wdata_i[2*NUM_SRC-1:NUM_SRC];
    end
  end

  assign set_vec = rise_i & irq_en_q;
  assign clr_vec = stat_we_i ? stat_wdata_i : '0;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_vec) | set_vec;
  end

  assign ad_fire_o = rise_i & ad_en_q;
  assign stat_o    = stat_q;
  assign irq_o     = |(stat_q & irq_en_q);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && |(stat_wdata_i & ~set_vec)) |=>
      (stat_q & $past(stat_wdata_i & ~set_vec)) == '0);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> (stat_q & $past(set_vec)) == $past(set_vec));
  assert_irq_has_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|stat_q));
endmodule

// File: rtl/bit_interval_trigger.sv
module bit_interval_trigger
  import ivt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               stat_we_i,
  input  logic [NUM_SRC-1:0] stat_wdata_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               irq_o,
  output logic               ad_trig_o
);
  logic [CNT_W-1:0]   cnt_nxt;
  logic [NUM_SRC-1:0] rise, ad_fire;
  logic               ad_q;

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .cnt_en_i,
    .cnt_o, .cnt_nxt_o(cnt_nxt)
  );

  ivt_rise_detect #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .WATCH_LSB(WATCH_LSB)) u_rise (
    .clk_i, .rst_ni, .cnt_en_i,
    .cnt_i(cnt_o), .cnt_nxt_i(cnt_nxt), .rise_o(rise)
  );

  ivt_status #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .stat_we_i, .stat_wdata_i,
    .rise_i(rise), .stat_o, .ad_fire_o(ad_fire), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ad_q <= 1'b0;
    else         ad_q <= |ad_fire;
  end
  assign ad_trig_o = ad_q;

  assert_ad_one_clock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_trig_o |=> !ad_trig_o);
endmodule

// File: tb/bit_interval_trigger_tb.sv
module bit_interval_trigger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, cfg_we = 1'b0, stat_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  stat_wdata = '0;
  logic [3:0]  stat;
  logic [31:0] cnt;
  logic        irq, ad;
  int checks = 0, fails = 0, ad_pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bit_interval_trigger u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .stat_we_i(stat_we), .stat_wdata_i(stat_wdata),
    .stat_o(stat), .cnt_o(cnt), .irq_o(irq), .ad_trig_o(ad)
  );

  // {ad_en, irq_en, steps, exp_stat, exp_pulses, exp_irq}
  typedef struct packed {
    logic [3:0]  ad_en;
    logic [3:0]  irq_en;
    logic [15:0] steps;
    logic [3:0]  stat;
    logic [7:0]  pulses;
    logic        irq;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{4'b0001, 4'b0001, 16'd64,  4'b0001, 8'd1, 1'b1},
    '{4'b0000, 4'b0010, 16'd127, 4'b0000, 8'd0, 1'b0},
    '{4'b0010, 4'b0010, 16'd128, 4'b0010, 8'd1, 1'b1},
    '{4'b0000, 4'b1111, 16'd512, 4'b1111, 8'd0, 1'b1},
    '{4'b1111, 4'b0000, 16'd512, 4'b0000, 8'd8, 1'b0},
    '{4'b1000, 4'b0100, 16'd300, 4'b0100, 8'd0, 1'b1},
    '{4'b0100, 4'b1000, 16'd511, 4'b0000, 8'd1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (ad === 1'b1) ad_pulses++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cnt_en = 0; cfg_we = 0; stat_we = 0;
    run(2);
    rst_n = 1'b1;
    ad_pulses = 0;
  endtask

  task automatic write_cfg(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    run(1);
    cfg_we = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 cnt", cnt, 0);
    chk("R1 stat", {28'd0, stat}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 ad", {31'd0, ad}, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_cfg({VT[v].ad_en, VT[v].irq_en});
      ad_pulses = 0;
      cnt_en = 1'b1;
      run(int'(VT[v].steps));
      cnt_en = 1'b0;
      chk("R2 table cnt", cnt, {16'd0, VT[v].steps});
      chk("R3 R4 table stat", {28'd0, stat}, {28'd0, VT[v].stat});
      chk("R5 R9 table pulses", ad_pulses, {24'd0, VT[v].pulses});
      chk("R6 table irq", {31'd0, irq}, {31'd0, VT[v].irq});
    end

    // directed sequence on source 0 (bit 6)
    do_reset();
    write_cfg(8'b0000_0001);
    run(10);
    chk("R2 hold with enable low", cnt, 0);
    cnt_en = 1'b1; run(63); cnt_en = 1'b0;
    run(5);
    chk("R2 hold at 63", cnt, 63);
    chk("R3 no event while held", {28'd0, stat}, 0);
    cnt_en = 1'b1; run(1);
    chk("R4 flag at 0x40", {28'd0, stat}, 4'b0001);
    chk("R6 irq on flag", {31'd0, irq}, 1);
    run(64);
    chk("R3 falling bit keeps state", {28'd0, stat}, 4'b0001);
    stat_we = 1'b1; stat_wdata = 4'b1110; run(1); stat_we = 1'b0;
    chk("R7 zero mask bit untouched", {28'd0, stat}, 4'b0001);
    run(62);
    chk("R2 before collision", cnt, 191);
    stat_we = 1'b1; stat_wdata = 4'b0001; run(1); stat_we = 1'b0;
    chk("R8 set beats clear", {28'd0, stat}, 4'b0001);
    cfg_we = 1'b1; cfg_wdata = 8'h00; run(1); cfg_we = 1'b0;
    chk("R6 masked flag kept", {28'd0, stat}, 4'b0001);
    chk("R6 R10 masked irq low", {31'd0, irq}, 0);
    cfg_wdata = 8'hFF; run(1);
    chk("R10 no write without strobe", {31'd0, irq}, 0);
    stat_we = 1'b1; stat_wdata = 4'b0001; run(1); stat_we = 1'b0;
    chk("R7 flag cleared", {28'd0, stat}, 0);
    ad_pulses = 0;
    run(70);
    chk("R9 disabled source silent stat", {28'd0, stat}, 0);
    chk("R9 disabled source silent ad", ad_pulses, 0);
    cnt_en = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule